// File: doc/BRIEF.md
# Serial Transmit Controller with Break Queueing and Idle Flags

This block is the transmit half of an asynchronous serial port. Software writes a byte into a one-entry holding buffer; at the start of each character the buffer contents move into a shift register and go out on the line one bit per bit-time tick. The block also sends an all-ones preamble whenever the transmitter is switched on, and sends break characters (a run of zeros) when software toggles a break control bit. The break length is 10 bit times, or 13 with the long-break select set.

Two status flags are kept for the host. The buffer-empty flag says that a new byte may be written. The idle flag says that the buffer is empty and the line carries no data, preamble or break. Bit-time generation comes from outside as a one-cycle tick. The block has no parity and no interrupts.

Top module: `uart_tx_ctl`

## Requirements
- R1: After reset `txd` is 1, `buf_empty` and `tx_done` are 1, and `status` reads 8'hC0: bit 7 is the buffer-empty flag, bit 6 is the idle flag, and bits 5..0 are 0.
- R2: A data character is one start bit of 0, the 8 data bits least significant first, then one stop bit of 1. Each bit lasts from one accepted `bit_tick` to the next. `txd` changes only at clock edges where `bit_tick` is 1, and it is 1 whenever nothing is being sent.
- R3: A `data_wr` pulse clears `buf_empty` at the next clock edge. `buf_empty` sets again at the same edge that moves the buffered byte into the shift register, which is always a `bit_tick` edge.
- R4: A 0-to-1 change of `tx_enable` queues a preamble of 10 bit times of 1.
- R5: A 0-to-1 change of `break_req` queues a break of logic 0 lasting 10 bit times. When `break_long` is 1 at the moment the break starts, the break lasts 13 bit times.
- R6: Each break that starts while `break_req` is still 1 queues another break. A break queued this way is still sent after `break_req` returns to 0.
- R7: When one character ends, the next one is chosen in this order: queued break first, then queued preamble, then buffered data.
- R8: `tx_done` clears at the edge after a data write, a `tx_enable` rise or a `break_req` rise. It sets one cycle after the line is idle with the buffer empty and no break or preamble queued.
- R9: Characters are sent back to back: when work is queued, the next character starts on the same tick that ends the previous one.
- R10: While `tx_enable` is 0, no new character starts. Queued data, preamble and breaks wait until the transmitter is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_wr | input | 1 | One-cycle strobe that writes `data_in` into the buffer |
| data_in | input | 8 | Byte to transmit |
| tx_enable | input | 1 | Transmitter enable; a rise queues a preamble |
| break_req | input | 1 | Break control bit; a rise queues a break |
| break_long | input | 1 | Selects the 13-bit break length |
| bit_tick | input | 1 | One-cycle pulse at every bit-time boundary |
| txd | output | 1 | Serial line, idle high |
| buf_empty | output | 1 | Holding buffer has room |
| tx_done | output | 1 | Transmitter idle |
| status | output | 8 | Status byte {buf_empty, tx_done, 6'b0} |

## Verification
The bench measures exact line sequences tick by tick. It counts break zeros at both lengths. This catches an off-by-one in the bit counter, which would send 9 or 11 zeros, and a length select that is ignored. It also holds `break_req` across a break boundary. A design that ignores the held level sends only one break, and a design that drops the re-queued break on release ends after 20 zeros instead of 30.

It sends a break with data queued behind it, and a break together with a preamble. A wrong priority shows up as a start bit or ones in the positions where zeros belong. It also writes data while the transmitter is disabled. A design that does not gate starts would send that data at once, before the preamble. Finally, it checks that `buf_empty` sets exactly on the tick where the character begins, so a flag set at write time or at frame end is caught.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    CH_NONE = 2'd0,
    CH_DATA = 2'd1,
    CH_PRE  = 2'd2,
    CH_BRK  = 2'd3
  } char_kind_e;
endpackage

// File: rtl/uart_tx_holdbuf.sv
module uart_tx_holdbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_val,
  input  logic              take,
  output logic [DATA_W-1:0] hold_val,
  output logic              empty_o
);
  logic [DATA_W-1:0] val_q, val_d;
  logic              empty_q, empty_d;

  // A write in the same cycle as a take wins: the old byte leaves, the new one stays.
  always_comb begin
    val_d   = val_q;
    empty_d = empty_q;
    if (wr_en) begin
      val_d   = wr_val;
      empty_d = 1'b0;
    end else if (take) begin
      empty_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q   <= '0;
      empty_q <= 1'b1;
    end else begin
      val_q   <= val_d;
      empty_q <= empty_d;
    end
  end

  assign hold_val = val_q;
  assign empty_o  = empty_q;
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BRK_SHORT = 10,
  parameter int BRK_LONG  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              load,
  input  char_kind_e        kind,
  input  logic [DATA_W-1:0] data_val,
  input  logic              long_sel,
  output logic              busy_o,
  output logic              last_o,
  output logic              txd_o
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int SH_W    = (FRAME_W > BRK_LONG) ? FRAME_W : BRK_LONG;
  localparam int CNT_W   = $clog2(SH_W + 1);

  logic [SH_W-1:0]  sh_q, sh_d, frame;
  logic [CNT_W-1:0] cnt_q, cnt_d, len;
  logic             busy_q, busy_d;

  // Character image, bit 0 goes out first; length in bit times.
  always_comb begin
    frame = '1;
    len   = CNT_W'(FRAME_W);
    unique case (kind)
      CH_DATA: frame[FRAME_W-1:0] = {1'b1, data_val, 1'b0};
      CH_BRK: begin
        frame = '0;
        len   = long_sel ? CNT_W'(BRK_LONG) : CNT_W'(BRK_SHORT);
      end
      default: frame = '1;
    endcase
  end

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (bit_tick) begin
      if (load) begin
        sh_d   = frame;
        cnt_d  = len - 1'b1;
        busy_d = 1'b1;
      end else if (busy_q && (cnt_q != '0)) begin
        sh_d  = {1'b1, sh_q[SH_W-1:1]};
        cnt_d = cnt_q - 1'b1;
      end else begin
        busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;
  assign last_o = busy_q && (cnt_q == '0);
  assign txd_o  = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/uart_tx_sequencer.sv
module uart_tx_sequencer
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       tx_enable,
  input  logic       break_req,
  input  logic       wr_en,
  input  logic       buf_empty,
  input  logic       busy,
  input  logic       last,
  output logic       load,
  output char_kind_e kind,
  output logic       done_o
);
  logic en_q, brq_q, brk_pend_q, brk_pend_d, pre_pend_q, pre_pend_d, done_q, done_d;
  logic slot, en_rise, brk_rise, clr_done;

  assign en_rise  = tx_enable && !en_q;
  assign brk_rise = break_req && !brq_q;
  assign clr_done = wr_en || en_rise || brk_rise;
  assign slot     = bit_tick && tx_enable && (!busy || last);

  // Fixed priority among queued work.
  always_comb begin
    if (brk_pend_q)      kind = CH_BRK;
    else if (pre_pend_q) kind = CH_PRE;
    else if (!buf_empty) kind = CH_DATA;
    else                 kind = CH_NONE;
  end

  assign load = slot && (kind != CH_NONE);

  always_comb begin
    brk_pend_d = brk_pend_q;
    if (brk_rise)                    brk_pend_d = 1'b1;
    else if (load && kind == CH_BRK) brk_pend_d = break_req;
    pre_pend_d = pre_pend_q;
    if (en_rise)                     pre_pend_d = 1'b1;
    else if (load && kind == CH_PRE) pre_pend_d = 1'b0;
    done_d = !clr_done && buf_empty && !busy && !brk_pend_q && !pre_pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      brq_q      <= 1'b0;
      brk_pend_q <= 1'b0;
      pre_pend_q <= 1'b0;
      done_q     <= 1'b1;
    end else begin
      en_q       <= tx_enable;
      brq_q      <= break_req;
      brk_pend_q <= brk_pend_d;
      pre_pend_q <= pre_pend_d;
      done_q     <= done_d;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/uart_tx_ctl.sv
module uart_tx_ctl
  import uart_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BRK_SHORT = 10,
  parameter int BRK_LONG  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_in,
  input  logic              tx_enable,
  input  logic              break_req,
  input  logic              break_long,
  input  logic              bit_tick,
  output logic              txd,
  output logic              buf_empty,
  output logic              tx_done,
  output logic [7:0]        status
);
  logic              load, busy, last, take;
  logic [DATA_W-1:0] hold_val;
  char_kind_e        kind;

  assign take = load && (kind == CH_DATA);

  uart_tx_holdbuf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .wr_val(data_in),
    .take(take), .hold_val(hold_val), .empty_o(buf_empty)
  );

  uart_tx_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_enable(tx_enable),
    .break_req(break_req), .wr_en(data_wr), .buf_empty(buf_empty),
    .busy(busy), .last(last), .load(load), .kind(kind), .done_o(tx_done)
  );

  uart_tx_shifter #(.DATA_W(DATA_W), .BRK_SHORT(BRK_SHORT), .BRK_LONG(BRK_LONG)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .load(load), .kind(kind),
    .data_val(hold_val), .long_sel(break_long), .busy_o(busy), .last_o(last),
    .txd_o(txd)
  );

  assign status = {buf_empty, tx_done, 6'b0};
endmodule

// File: rtl/uart_tx_ctl_chk.sv
module uart_tx_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic data_wr,
  input logic tx_enable,
  input logic break_req,
  input logic bit_tick,
  input logic txd,
  input logic buf_empty,
  input logic tx_done
);
  assert_idle_line_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> txd);

  assert_line_moves_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(txd));

  assert_write_fills_R3: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !buf_empty);

  assert_empty_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> $past(bit_tick));

  assert_write_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !tx_done);

  assert_enable_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_enable) |=> !tx_done);

  assert_break_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(break_req) |=> !tx_done);

  assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_enable && tx_done) |=> txd);
endmodule

bind uart_tx_ctl uart_tx_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .tx_enable(tx_enable),
  .break_req(break_req), .bit_tick(bit_tick), .txd(txd),
  .buf_empty(buf_empty), .tx_done(tx_done)
);

// File: tb/uart_tx_ctl_bench.sv
`timescale 1ns/1ps
module uart_tx_ctl_bench;
  localparam int DIV = 4;

  logic       clk, rst_n, data_wr, tx_enable, break_req, break_long, bit_tick;
  logic [7:0] data_in, status;
  logic       txd, buf_empty, tx_done;

  int n_chk, n_bad, ln, div;
  logic lg [0:511];

  uart_tx_ctl u_uart_tx_ctl (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_in(data_in),
    .tx_enable(tx_enable), .break_req(break_req), .break_long(break_long),
    .bit_tick(bit_tick), .txd(txd), .buf_empty(buf_empty), .tx_done(tx_done),
    .status(status)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Tick generator and line log: one entry per bit period, taken after each tick edge.
  initial begin
    bit_tick = 1'b0;
    div = 0;
    ln = 0;
    forever begin
      @(negedge clk);
      if (bit_tick && ln < 512) begin
        lg[ln] = txd;
        ln++;
      end
      bit_tick = (div == DIV-1);
      div = bit_tick ? 0 : div + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic align();
    @(posedge clk iff bit_tick);
    @(negedge clk);
    #2;
  endtask

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    step();
    while (!tx_done && n < 3000) begin
      step();
      n++;
    end
    chk(tx_done == 1'b1, req, "tx_done returns", int'(tx_done), 1);
  endtask

  task automatic check_frame(input int base, input logic [7:0] d, input string req);
    chk(lg[base] == 1'b0, req, "start bit", int'(lg[base]), 0);
    for (int i = 0; i < 8; i++)
      chk(lg[base+1+i] == d[i], req, $sformatf("data bit %0d", i), int'(lg[base+1+i]), int'(d[i]));
    chk(lg[base+9] == 1'b1, req, "stop bit", int'(lg[base+9]), 1);
  endtask

  function automatic int zero_run();
    int n = 0;
    while (n < ln && lg[n] == 1'b0) n++;
    return n;
  endfunction

  task automatic t_reset();
    chk(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
    chk(status == 8'hC0, "R1", "status after reset", int'(status), 8'hC0);
    chk(buf_empty && tx_done, "R1", "flags after reset", int'({buf_empty, tx_done}), 3);
  endtask

  task automatic t_preamble_data();
    align();
    tx_enable = 1'b1; data_wr = 1'b1; data_in = 8'hA5; ln = 0;
    step();
    data_wr = 1'b0;
    chk(tx_done == 1'b0, "R8", "done cleared by enable rise", int'(tx_done), 0);
    wait_done("R4");
    for (int i = 0; i < 10; i++)
      chk(lg[i] == 1'b1, "R4", $sformatf("preamble bit %0d", i), int'(lg[i]), 1);
    check_frame(10, 8'hA5, "R7");
  endtask

  task automatic t_single();
    align();
    data_wr = 1'b1; data_in = 8'h3C; ln = 0;
    step();
    data_wr = 1'b0;
    chk(buf_empty == 1'b0, "R3", "empty cleared by write", int'(buf_empty), 0);
    chk(tx_done == 1'b0, "R8", "done cleared by write", int'(tx_done), 0);
    align();
    chk(buf_empty == 1'b1, "R3", "empty set at load tick", int'(buf_empty), 1);
    wait_done("R8");
    check_frame(0, 8'h3C, "R2");
    chk(lg[10] == 1'b1, "R2", "idle after stop", int'(lg[10]), 1);
  endtask

  task automatic t_back_to_back();
    align();
    data_wr = 1'b1; data_in = 8'h81; ln = 0;
    step();
    data_wr = 1'b0;
    align();
    data_wr = 1'b1; data_in = 8'h5E;
    step();
    data_wr = 1'b0;
    wait_done("R9");
    check_frame(0, 8'h81, "R9");
    check_frame(10, 8'h5E, "R9");
  endtask

  task automatic t_break(input logic lng, input int exp_len);
    align();
    break_long = lng; break_req = 1'b1; ln = 0;
    step();
    break_req = 1'b0;
    chk(tx_done == 1'b0, "R8", "done cleared by break rise", int'(tx_done), 0);
    wait_done("R5");
    chk(zero_run() == exp_len, "R5", "break length", zero_run(), exp_len);
    break_long = 1'b0;
  endtask

  task automatic t_break_held();
    align();
    break_req = 1'b1; ln = 0;
    repeat (62) @(negedge clk);
    #2;
    break_req = 1'b0;
    wait_done("R6");
    chk(zero_run() == 30, "R6", "held break zeros", zero_run(), 30);
  endtask

  task automatic t_prio_brk_data();
    align();
    break_req = 1'b1; data_wr = 1'b1; data_in = 8'h01; ln = 0;
    step();
    break_req = 1'b0; data_wr = 1'b0;
    wait_done("R7");
    for (int i = 0; i < 10; i++)
      chk(lg[i] == 1'b0, "R7", $sformatf("break before data bit %0d", i), int'(lg[i]), 0);
    check_frame(10, 8'h01, "R7");
  endtask

  task automatic t_disabled();
    align();
    tx_enable = 1'b0;
    step();
    data_wr = 1'b1; data_in = 8'hC3; ln = 0;
    step();
    data_wr = 1'b0;
    repeat (30 * DIV) @(negedge clk);
    #2;
    chk(zero_run() == 0 && ln >= 29, "R10", "line quiet while disabled", zero_run(), 0);
    chk(buf_empty == 1'b0, "R10", "data held while disabled", int'(buf_empty), 0);
    chk(tx_done == 1'b0, "R10", "not idle while data held", int'(tx_done), 0);
    align();
    tx_enable = 1'b1; ln = 0;
    wait_done("R10");
    chk(zero_run() == 0, "R4", "preamble before held data", zero_run(), 0);
    check_frame(10, 8'hC3, "R10");
  endtask

  task automatic t_prio_brk_pre();
    align();
    tx_enable = 1'b0;
    step();
    align();
    tx_enable = 1'b1; break_req = 1'b1; ln = 0;
    step();
    break_req = 1'b0;
    wait_done("R7");
    chk(zero_run() == 10, "R7", "break ahead of preamble", zero_run(), 10);
    chk(ln == 21, "R7", "preamble follows break", ln, 21);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; data_wr = 1'b0; data_in = 8'h00;
    tx_enable = 1'b0; break_req = 1'b0; break_long = 1'b0;
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    step();
    t_reset();
    t_preamble_data();
    t_single();
    t_back_to_back();
    t_break(1'b0, 10);
    t_break(1'b1, 13);
    t_break_held();
    t_prio_brk_data();
    t_disabled();
    t_prio_brk_pre();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule